// File: doc/BRIEF.md
# Grouped-Access Register File

This block is a 32-entry, 32-bit register file for a compute datapath. It has two read ports and one write port. Each port carries a base register index and a 2-bit size code. One access moves one register, an aligned pair of registers or an aligned group of four. The port buses are therefore 128 bits wide. Register `base+k` sits in lane k, which is bits `32k+31:32k`, and any lane above the access size is zero.

Alignment is checked in hardware on every port. A pair must start on an even index. A group of four must start on an index that is a multiple of four. Size code 11 is reserved. A request that breaks these rules is dropped and raises that port's error flag in the next cycle for one cycle.

Read results are registered and appear one cycle after the request. A read issued in the same cycle as a write sees the newly written words. This holds even where the two groups only partly overlap. The asynchronous active-low reset is released synchronously inside the block, and it clears every register to zero.

Top module: `grpreg_file`

## Requirements
- R1: After reset release, every register reads as zero on both read ports.
- R2: Size code 00 reads any index. One cycle after the request, lane 0 holds that register and bits 127:32 are zero.
- R3: Size code 01 with an even base returns register base in lane 0 and base+1 in lane 1, with bits 127:64 zero, one cycle after the request.
- R4: Size code 10 with a base that is a multiple of four returns registers base..base+3 in lanes 0..3, one cycle after the request.
- R5: A legal write of size 00, 01 or 10 loads lane k into register base+k for each covered register and changes no other register.
- R6: A read with size 01 and an odd base, size 10 and a base not a multiple of four, or size 11, raises `rdN_err` for one cycle in the cycle after the request and drives `rdN_data` to zero.
- R7: A write with an illegal size/base pair raises `wr_err` for one cycle in the next cycle and changes no register.
- R8: A read issued in the same cycle as a write returns the written value for every register that both accesses cover.
- R9: The two read ports work independently in the same cycle, including when they name the same registers.
- R10: Error flags are low in any cycle that follows a cycle with no request on that port, or a legal request on it.
- R11: While `rdN_en` is low, `rdN_data` holds the last value it returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write base register index |
| wr_size | input | 2 | Write size code: 00 one, 01 pair, 10 four, 11 reserved |
| wr_data | input | 128 | Write data; lane k goes to register base+k |
| wr_err | output | 1 | Write rejected (one-cycle pulse) |
| rd0_en | input | 1 | Read port 0 request |
| rd0_idx | input | 5 | Read port 0 base index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 128 | Read port 0 result, registered |
| rd0_err | output | 1 | Read port 0 request rejected |
| rd1_en | input | 1 | Read port 1 request |
| rd1_idx | input | 5 | Read port 1 base index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 128 | Read port 1 result, registered |
| rd1_err | output | 1 | Read port 1 request rejected |

## Verification
The bench targets several corner cases, and each has a typical failure mode:
- **Partial overlap with a same-cycle write.** A pair read starts inside a four-register write in the same cycle. A design without the bypass, or with the bypass applied only on an exact base match, returns stale words in some lanes.
- **Odd-based pairs and quad bases off by two.** A design that checks only the low index bit for groups of four would write or read across a group boundary instead of flagging the request.
- **Reserved size code.** A design that does not reject code 11 would quietly treat it as a four-register access.
- **Rejected writes.** These are followed by reads of the targeted registers, which exposes any partial update.
- **Idle cycles.** These show whether read data holds while idle and whether a stale error flag survives its single cycle.

// File: rtl/grpreg_pkg.sv
package grpreg_pkg;
  typedef enum logic [1:0] {
    GS_ONE  = 2'b00,
    GS_TWO  = 2'b01,
    GS_FOUR = 2'b10,
    GS_RSVD = 2'b11
  } grp_size_e;
endpackage

// File: rtl/grpreg_rst_sync.sv
module grpreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/grpreg_align.sv
module grpreg_align
  import grpreg_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LANES = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  output logic             bad,
  output logic [LANES-1:0] lane_mask
);
  grp_size_e sz;

  always_comb begin
    sz        = grp_size_e'(size);
    bad       = 1'b0;
    lane_mask = '0;
    unique case (sz)
      GS_ONE:  lane_mask = LANES'(4'b0001);
      GS_TWO:  begin
        bad       = idx[0];
        lane_mask = LANES'(4'b0011);
      end
      GS_FOUR: begin
        bad       = |idx[1:0];
        lane_mask = LANES'(4'b1111);
      end
      default: bad = 1'b1;
    endcase
    if (bad) lane_mask = '0;
  end

  // R6: a rejected request must not select any lane
  always_comb begin
    assert_mask_clear_on_bad_R6: assert (!(bad && (|lane_mask)));
  end
endmodule

// File: rtl/grpreg_rdport.sv
module grpreg_rdport
  import grpreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int WORD_W   = 32,
  parameter int LANES    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int BUS_W   = WORD_W * LANES
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [1:0]                       size,
  input  logic [NUM_REGS-1:0][WORD_W-1:0]  regs,
  output logic [BUS_W-1:0]                 data,
  output logic                             err
);
  logic             bad;
  logic [LANES-1:0] mask;
  logic [BUS_W-1:0] gather;
  logic [BUS_W-1:0] data_nxt;
  logic             err_nxt;
  logic [BUS_W-1:0] data_q;
  logic             err_q;

  grpreg_align #(.IDX_W(IDX_W), .LANES(LANES)) u_align (
    .idx       (idx),
    .size      (size),
    .bad       (bad),
    .lane_mask (mask)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0] sel;
    assign sel = idx + IDX_W'(k);
    assign gather[k*WORD_W +: WORD_W] = mask[k] ? regs[sel] : '0;
  end

  always_comb begin
    data_nxt = bad ? '0 : gather;
    err_nxt  = en && bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_nxt;
      if (en) data_q <= data_nxt;
    end
  end

  assign data = data_q;
  assign err  = err_q;

  assert_err_data_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (data == '0));
  assert_single_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bad && size == GS_ONE) |=> (data[BUS_W-1:WORD_W] == '0));
  assert_bad_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bad) |=> err);
  assert_idle_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !err);
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(data));
endmodule

// File: rtl/grpreg_file.sv
module grpreg_file
  import grpreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int WORD_W   = 32,
  parameter int LANES    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int BUS_W   = WORD_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_size,
  input  logic [BUS_W-1:0] wr_data,
  output logic             wr_err,
  input  logic             rd0_en,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [1:0]       rd0_size,
  output logic [BUS_W-1:0] rd0_data,
  output logic             rd0_err,
  input  logic             rd1_en,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [1:0]       rd1_size,
  output logic [BUS_W-1:0] rd1_data,
  output logic             rd1_err
);
  logic                            rst_s_n;
  logic                            wr_bad;
  logic [LANES-1:0]                wr_mask;
  logic                            wr_go;
  logic                            wr_err_q;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs_nxt;

  grpreg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  grpreg_align #(.IDX_W(IDX_W), .LANES(LANES)) u_wr_align (
    .idx       (wr_idx),
    .size      (wr_size),
    .bad       (wr_bad),
    .lane_mask (wr_mask)
  );

  assign wr_go = wr_en && !wr_bad;

  // next-state storage image; read ports sample it, giving write-through
  always_comb begin
    regs_nxt = regs_q;
    if (wr_go) begin
      for (int k = 0; k < LANES; k++) begin
        if (wr_mask[k]) regs_nxt[wr_idx + IDX_W'(k)] = wr_data[k*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      regs_q   <= '0;
      wr_err_q <= 1'b0;
    end else begin
      wr_err_q <= wr_en && wr_bad;
      if (wr_go) regs_q <= regs_nxt;
    end
  end

  assign wr_err = wr_err_q;

  grpreg_rdport #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .LANES(LANES)) u_rd0 (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (rd0_en),
    .idx   (rd0_idx),
    .size  (rd0_size),
    .regs  (regs_nxt),
    .data  (rd0_data),
    .err   (rd0_err)
  );

  grpreg_rdport #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .LANES(LANES)) u_rd1 (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (rd1_en),
    .idx   (rd1_idx),
    .size  (rd1_size),
    .regs  (regs_nxt),
    .data  (rd1_data),
    .err   (rd1_err)
  );

  assert_bad_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && wr_bad) |=> (regs_q == $past(regs_q)));
  assert_bad_write_flag_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && wr_bad) |=> wr_err);
  assert_wr_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!wr_en) |=> !wr_err);
  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && wr_size == GS_ONE) |=> (regs_q[$past(wr_idx)] == $past(wr_data[WORD_W-1:0])));
endmodule

// File: tb/grpreg_file_tb.sv
`timescale 1ns/1ps
module grpreg_file_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [4:0]   wr_idx;
  logic [1:0]   wr_size;
  logic [127:0] wr_data;
  logic         wr_err;
  logic         rd0_en, rd1_en;
  logic [4:0]   rd0_idx, rd1_idx;
  logic [1:0]   rd0_size, rd1_size;
  logic [127:0] rd0_data, rd1_data;
  logic         rd0_err, rd1_err;

  int tests = 0;
  int fails = 0;
  logic [31:0]  model [32];
  logic [127:0] exp0 = '0;
  logic [127:0] exp1 = '0;

  always #4 clk = ~clk;

  grpreg_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
    .rd0_en(rd0_en), .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_en(rd1_en), .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_err(rd1_err)
  );

  function automatic bit is_bad(input logic [4:0] i, input logic [1:0] s);
    return (s == 2'b11) || (s == 2'b01 && i[0]) || (s == 2'b10 && i[1:0] != 2'b00);
  endfunction

  function automatic int nwords(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [127:0] gather(input logic [4:0] i, input logic [1:0] s);
    logic [127:0] r = '0;
    for (int k = 0; k < nwords(s); k++) r[k*32 +: 32] = model[(int'(i) + k) % 32];
    return r;
  endfunction

  task automatic chk128(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model write then reads (bypass), check next negedge
  task automatic step(input logic we, input logic [4:0] wi, input logic [1:0] ws, input logic [127:0] wd,
                      input logic e0, input logic [4:0] i0, input logic [1:0] s0,
                      input logic e1, input logic [4:0] i1, input logic [1:0] s1,
                      input string tag);
    logic xw, x0, x1;
    wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
    rd0_en = e0; rd0_idx = i0; rd0_size = s0;
    rd1_en = e1; rd1_idx = i1; rd1_size = s1;
    xw = we && is_bad(wi, ws);
    x0 = e0 && is_bad(i0, s0);
    x1 = e1 && is_bad(i1, s1);
    if (we && !xw) for (int k = 0; k < nwords(ws); k++) model[(int'(wi) + k) % 32] = wd[k*32 +: 32];
    if (e0) exp0 = x0 ? '0 : gather(i0, s0);
    if (e1) exp1 = x1 ? '0 : gather(i1, s1);
    @(posedge clk);
    @(negedge clk);
    chk128({tag, " rd0_data"}, rd0_data, exp0);
    chk1({tag, " rd0_err"}, rd0_err, x0);
    chk128({tag, " rd1_data"}, rd1_data, exp1);
    chk1({tag, " rd1_err"}, rd1_err, x1);
    chk1({tag, " wr_err"}, wr_err, xw);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 5'd0, 2'b00, '0, 1'b0, 5'd0, 2'b00, 1'b0, 5'd0, 2'b00, tag);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 32; r++) model[r] = '0;
    rst_n = 1'b0;
    wr_en = 0; wr_idx = 0; wr_size = 0; wr_data = '0;
    rd0_en = 0; rd0_idx = 0; rd0_size = 0;
    rd1_en = 0; rd1_idx = 0; rd1_size = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: all registers zero after reset
    for (int g = 0; g < 8; g += 2)
      step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'(g*4), 2'b10, 1'b1, 5'(g*4+4), 2'b10, "R1");

    // R5 and R4: fill every register through quad writes, read back as quads
    for (int g = 0; g < 8; g++) step(1'b1, 5'(g*4), 2'b10, rnd128(), 1'b0, 5'd0, 2'b00, 1'b0, 5'd0, 2'b00, "R5");
    for (int g = 0; g < 8; g++) step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'(g*4), 2'b10, 1'b1, 5'(g*4), 2'b10, "R4");

    // R2: single reads at odd index; R3: pair reads
    step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'd31, 2'b00, 1'b1, 5'd7, 2'b00, "R2");
    step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'd30, 2'b01, 1'b1, 5'd6, 2'b01, "R3");

    // R5: single and pair writes touch only their registers
    step(1'b1, 5'd13, 2'b00, rnd128(), 1'b0, 5'd0, 2'b00, 1'b0, 5'd0, 2'b00, "R5");
    step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'd12, 2'b10, 1'b0, 5'd0, 2'b00, "R5");
    step(1'b1, 5'd18, 2'b01, rnd128(), 1'b0, 5'd0, 2'b00, 1'b0, 5'd0, 2'b00, "R5");
    step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'd16, 2'b10, 1'b0, 5'd0, 2'b00, "R5");

    // R6: misaligned pair, quad off by two, reserved size
    step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'd5, 2'b01, 1'b1, 5'd10, 2'b10, "R6");
    step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'd8, 2'b11, 1'b1, 5'd1, 2'b10, "R6");
    idle("R10");

    // R7: rejected writes leave storage unchanged
    step(1'b1, 5'd9, 2'b01, rnd128(), 1'b0, 5'd0, 2'b00, 1'b0, 5'd0, 2'b00, "R7");
    step(1'b1, 5'd4, 2'b11, rnd128(), 1'b1, 5'd8, 2'b10, 1'b0, 5'd0, 2'b00, "R7");
    step(1'b1, 5'd22, 2'b10, rnd128(), 1'b1, 5'd4, 2'b10, 1'b1, 5'd20, 2'b10, "R7");

    // R8: same-cycle write with partial overlap
    step(1'b1, 5'd8, 2'b10, rnd128(), 1'b1, 5'd10, 2'b01, 1'b1, 5'd11, 2'b00, "R8");
    step(1'b1, 5'd26, 2'b01, rnd128(), 1'b1, 5'd24, 2'b10, 1'b1, 5'd27, 2'b00, "R8");

    // R11: data holds while idle; R10: flags drop
    step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'd3, 2'b01, 1'b1, 5'd0, 2'b00, "R11");
    step(1'b0, 5'd0, 2'b00, '0, 1'b1, 5'd1, 2'b00, 1'b1, 5'd28, 2'b10, "R11");
    step(1'b1, 5'd0, 2'b10, rnd128(), 1'b0, 5'd0, 2'b00, 1'b0, 5'd0, 2'b00, "R11");
    idle("R10");

    // R9 and R8: random mix on both read ports with writes
    for (int n = 0; n < 600; n++) begin
      logic [4:0] wi, i0, i1;
      logic [1:0] ws, s0, s1;
      wi = 5'($urandom); i0 = 5'($urandom); i1 = 5'($urandom);
      ws = 2'($urandom); s0 = 2'($urandom); s1 = 2'($urandom);
      if ($urandom % 4 != 0) begin wi[1:0] = 2'b00; i0[1:0] = 2'b00; if (s0 == 2'b11) s0 = 2'b01; end
      if ($urandom % 3 == 0) i1 = i0;
      step(1'($urandom), wi, ws, rnd128(), 1'($urandom), i0, s0, 1'($urandom), i1, s1, "R9");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule